// File: doc/BRIEF.md
# Output-Compare Timer Channel

This block is a general-purpose timer slice. A programmable prescaler divides the input clock; an up-counter steps once per prescaler period, wraps to zero after it reaches a reload limit, and raises a sticky update flag at each wrap. One compare channel watches the counter and drives an output pin according to a 3-bit mode code.

Software reaches the block through a simple single-cycle write port. The port carries a prescaler value, a reload limit, a compare value, a channel control byte and a status clear. The channel control byte selects the output behaviour: frozen, set, clear or toggle on a compare match, forced low or forced high, and two pulse-width modes. The control byte also holds a compare preload option, a direction field, an output enable and an external-clear enable. The prescaler value is always double-buffered, so a new division ratio starts on a clean period boundary.

Register addresses: 0 prescaler, 1 reload limit, 2 compare value, 3 channel control, 4 status. Channel control bits: [2:0] mode, [3] compare preload, [5:4] direction select, [6] output enable, [7] external-clear enable.

Top module: `oc_timer_unit`

## Requirements
- R1: After reset the counter, update flag and output pin are 0. The prescaler and compare value are 0, the reload limit is all ones, and the control byte is 0.
- R2: The counter advances once every (active prescaler + 1) clocks. On a step where the counter is at or above the reload limit, it goes to 0 instead of incrementing (a wrap). A write to address 1 changes the limit from the next clock.
- R3: A wrap sets the update flag (uif_o). A write to address 4 with data bit 0 equal to 0 clears it. A wrap in the same cycle wins over the clear.
- R4: A write to address 0 lands in a shadow register. The prescaler only copies the shadow into its active value on a wrap.
- R5: With control bit 3 at 0, a compare write takes effect on the next clock. With bit 3 at 1, the write goes to a shadow register, which is copied to the active compare value on a wrap.
- R6: Mode 000 (frozen) leaves the reference level unchanged.
- R7: A match event occurs on the clock after a counter step when the new count equals the active compare value. On a match event, mode 001 sets the reference level, mode 010 clears it and mode 011 inverts it. The level updates one clock after the counter shows the matching value.
- R8: Mode 100 drives the reference level low and mode 101 drives it high, one clock after the mode is written.
- R9: Mode 110 makes the reference level high while the count is below the active compare value, and low otherwise. Mode 111 is the inverse. The level follows the count with one clock of delay.
- R10: When the direction field (bits 5:4) is not 00, oc_o is 0 and the reference level holds its value.
- R11: When the output enable (bit 6) is 0, oc_o is 0.
- R12: When bit 7 is 1 and ext_clr_i is high at a clock edge, oc_o is 0 from that edge until a wrap releases it. A new clear request in the same cycle as a wrap wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0..4) |
| wr_data_i | input | CNT_W | Register write data |
| ext_clr_i | input | 1 | External output-clear request |
| cnt_o | output | CNT_W | Current counter value |
| uif_o | output | 1 | Sticky update flag |
| oc_o | output | 1 | Compare channel output pin |

## Verification
The assertions assume reset is held across at least one clock edge. They assume every write is a one-cycle strobe, and that a count, once it is below the limit, only moves by one or returns to zero. The stimulus writes only addresses 0 to 4. It keeps reload and compare values small so that many wraps and matches fit in the run, including random limits that fall below the running count. The bench reference model resolves the same-cycle collisions (wrap against flag clear, wrap against clear request, wrap against compare write) by the priorities stated in R3, R5 and R12.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN = 3'd0,
    OCM_SET    = 3'd1,
    OCM_CLR    = 3'd2,
    OCM_TOG    = 3'd3,
    OCM_LOW    = 3'd4,
    OCM_HIGH   = 3'd5,
    OCM_PWM_A  = 3'd6,
    OCM_PWM_B  = 3'd7
  } oc_mode_e;

  typedef struct packed {
    logic       clr_en;
    logic       out_en;
    logic [1:0] dir_sel;
    logic       preload;
    oc_mode_e   mode;
  } ch_ctrl_t;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIM  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

endpackage

// File: rtl/oc_prescaler.sv
module oc_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [PSC_W-1:0] wdata_i,
  input  logic             upd_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] shadow_q, active_q, div_q;

  assign tick_o = (div_q == active_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      div_q    <= '0;
    end else begin
      if (upd_i) active_q <= shadow_q;
      if (wr_i)  shadow_q <= wdata_i;
      div_q <= tick_o ? '0 : div_q + PSC_W'(1);
    end
  end

endmodule

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             step_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             step_q;

  assign upd_o  = tick_i && (cnt_q >= lim_i);
  assign cnt_o  = cnt_q;
  assign step_o = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else begin
      step_q <= tick_i;
      if (tick_i) cnt_q <= upd_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ch_ctrl_t         ctrl_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             upd_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ext_clr_i,
  output logic             oc_o
);

  logic [CNT_W-1:0] cmp_sh_q, cmp_act_q;
  logic             ref_q, ref_d, clr_q;
  logic             match, below, chan_out;

  assign chan_out = (ctrl_i.dir_sel == 2'b00);
  assign match    = step_i && (cnt_i == cmp_act_q);
  assign below    = (cnt_i < cmp_act_q);

  always_comb begin
    ref_d = ref_q;
    unique case (ctrl_i.mode)
      OCM_FROZEN: ref_d = ref_q;
      OCM_SET:    if (match) ref_d = 1'b1;
      OCM_CLR:    if (match) ref_d = 1'b0;
      OCM_TOG:    if (match) ref_d = ~ref_q;
      OCM_LOW:    ref_d = 1'b0;
      OCM_HIGH:   ref_d = 1'b1;
      OCM_PWM_A:  ref_d = below;
      OCM_PWM_B:  ref_d = ~below;
      default:    ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_sh_q  <= '0;
      cmp_act_q <= '0;
      ref_q     <= 1'b0;
      clr_q     <= 1'b0;
    end else begin
      // wrap copy first, a direct write overrides it
      if (upd_i && ctrl_i.preload) cmp_act_q <= cmp_sh_q;
      if (cmp_wr_i) begin
        cmp_sh_q <= cmp_wdata_i;
        if (!ctrl_i.preload) cmp_act_q <= cmp_wdata_i;
      end
      if (chan_out) ref_q <= ref_d;
      if (ctrl_i.clr_en && ext_clr_i) clr_q <= 1'b1;
      else if (upd_i)                 clr_q <= 1'b0;
    end
  end

  assign oc_o = chan_out && ctrl_i.out_en && !clr_q && ref_q;

endmodule

// File: rtl/oc_timer_unit.sv
module oc_timer_unit
  import oc_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ext_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uif_o,
  output logic             oc_o
);

  localparam int unsigned CTRL_W = $bits(ch_ctrl_t);

  logic [CNT_W-1:0] lim_q;
  ch_ctrl_t         ctrl_q;
  logic             uif_q;
  logic             tick, upd, step;
  logic             wr_psc, wr_lim, wr_cmp, wr_ctrl, wr_stat;

  assign wr_psc  = wr_en_i && (wr_addr_i == A_PSC);
  assign wr_lim  = wr_en_i && (wr_addr_i == A_LIM);
  assign wr_cmp  = wr_en_i && (wr_addr_i == A_CMP);
  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_stat = wr_en_i && (wr_addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= '1;
      ctrl_q <= '0;
      uif_q  <= 1'b0;
    end else begin
      if (wr_lim)  lim_q  <= wr_data_i;
      if (wr_ctrl) ctrl_q <= ch_ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (upd)                         uif_q <= 1'b1;
      else if (wr_stat && !wr_data_i[0]) uif_q <= 1'b0;
    end
  end

  oc_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_psc),
    .wdata_i (wr_data_i[PSC_W-1:0]),
    .upd_i   (upd),
    .tick_o  (tick)
  );

  oc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .lim_i  (lim_q),
    .cnt_o  (cnt_o),
    .upd_o  (upd),
    .step_o (step)
  );

  oc_channel #(.CNT_W(CNT_W)) u_ch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl_q),
    .cmp_wr_i    (wr_cmp),
    .cmp_wdata_i (wr_data_i),
    .upd_i       (upd),
    .step_i      (step),
    .cnt_i       (cnt_o),
    .ext_clr_i   (ext_clr_i),
    .oc_o        (oc_o)
  );

  assign uif_o = uif_q;

endmodule

// File: rtl/oc_timer_unit_chk.sv
module oc_timer_unit_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             ext_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             uif_o,
  input logic             oc_o,
  input logic             clr_en_i
);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_o) |-> (cnt_o == '0 || cnt_o == $past(cnt_o) + CNT_W'(1)));

  // R3
  uif_set_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uif_o) |-> (cnt_o == '0));

  // R3
  uif_clear_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(uif_o) |-> $past(wr_en_i && wr_addr_i == 3'd4 && !wr_data_i[0]));

  // R10
  dir_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && wr_addr_i == 3'd3 && wr_data_i[5:4] != 2'b00) |-> !oc_o);

  // R11
  oe_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && wr_addr_i == 3'd3 && !wr_data_i[6]) |-> !oc_o);

  // R12
  ext_clear_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_en_i && ext_clr_i) |-> !oc_o);

endmodule

bind oc_timer_unit oc_timer_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ext_clr_i (ext_clr_i),
  .cnt_o     (cnt_o),
  .uif_o     (uif_o),
  .oc_o      (oc_o),
  .clr_en_i  (ctrl_q.clr_en)
);

// File: tb/oc_timer_unit_test.sv
module oc_timer_unit_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         ext_clr = 1'b0;
  logic [W-1:0] cnt;
  logic         uif, oc;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  oc_timer_unit #(.CNT_W(W), .PSC_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ext_clr_i(ext_clr), .cnt_o(cnt), .uif_o(uif), .oc_o(oc)
  );

  // behavioural reference state
  int m_div, m_psc_a, m_psc_s, m_cnt, m_lim, m_cmp_a, m_cmp_s, m_ctrl;
  bit m_step, m_ref, m_clr, m_uif;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_psc_a = 0; m_psc_s = 0; m_cnt = 0; m_lim = 'hFFFF;
      m_cmp_a = 0; m_cmp_s = 0; m_ctrl = 0;
      m_step = 0; m_ref = 0; m_clr = 0; m_uif = 0;
    end else begin
      bit tick, wrap, hit, lt, pre, nref, nclr, nuif;
      int mode, ndiv, ncnt, npa, nps, nca, ncs, nlim, nctrl;
      tick = (m_div == m_psc_a);
      wrap = tick && (m_cnt >= m_lim);
      hit  = m_step && (m_cnt == m_cmp_a);
      lt   = (m_cnt < m_cmp_a);
      mode = m_ctrl & 7;
      pre  = m_ctrl[3];
      nref = m_ref;
      if (((m_ctrl >> 4) & 3) == 0) begin
        if (mode == 1 && hit) nref = 1;
        if (mode == 2 && hit) nref = 0;
        if (mode == 3 && hit) nref = !m_ref;
        if (mode == 4) nref = 0;
        if (mode == 5) nref = 1;
        if (mode == 6) nref = lt;
        if (mode == 7) nref = !lt;
      end
      nclr = m_clr;
      if (m_ctrl[7] && ext_clr) nclr = 1; else if (wrap) nclr = 0;
      nuif = m_uif;
      if (wrap) nuif = 1;
      else if (wr_en && wr_addr == 4 && !wr_data[0]) nuif = 0;
      npa = wrap ? m_psc_s : m_psc_a;
      nps = (wr_en && wr_addr == 0) ? int'(wr_data) : m_psc_s;
      nca = (wrap && pre) ? m_cmp_s : m_cmp_a;
      ncs = m_cmp_s;
      if (wr_en && wr_addr == 2) begin
        ncs = wr_data;
        if (!pre) nca = wr_data;
      end
      nlim  = (wr_en && wr_addr == 1) ? int'(wr_data) : m_lim;
      nctrl = (wr_en && wr_addr == 3) ? int'(wr_data & 'hFF) : m_ctrl;
      ndiv  = tick ? 0 : m_div + 1;
      ncnt  = m_cnt;
      if (tick) ncnt = wrap ? 0 : ((m_cnt + 1) & 'hFFFF);
      m_step = tick; m_ref = nref; m_clr = nclr; m_uif = nuif;
      m_psc_a = npa; m_psc_s = nps; m_cmp_a = nca; m_cmp_s = ncs;
      m_lim = nlim; m_ctrl = nctrl; m_div = ndiv; m_cnt = ncnt;
    end
  end

  function automatic string oc_tag();
    string t;
    if (((m_ctrl >> 4) & 3) != 0) return "R10";
    if (!m_ctrl[6]) return "R11";
    if (m_clr) return "R12";
    case (m_ctrl & 7)
      0: t = "R6";
      1, 2, 3: t = "R7";
      4, 5: t = "R8";
      default: t = "R9";
    endcase
    if (m_ctrl[3]) t = {t, "/R5"};
    return t;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // every-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_oc;
      exp_oc = (((m_ctrl >> 4) & 3) == 0) && m_ctrl[6] && !m_clr && m_ref;
      check("R2/R4 cnt", int'(cnt), m_cnt);
      check("R3 uif", int'(uif), int'(m_uif));
      check({oc_tag(), " oc"}, int'(oc), int'(exp_oc));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    check("R1 cnt", int'(cnt), 0);
    check("R1 uif", int'(uif), 0);
    check("R1 oc", int'(oc), 0);
    // R2 basic wrap, R3 flag clear
    wr(1, 9);
    idle(40);
    wr(4, 0);
    idle(5);
    // R7 set / clear / toggle on match
    wr(2, 4);
    wr(3, 'h41);
    idle(25);
    wr(2, 7);
    wr(3, 'h42);
    idle(25);
    wr(3, 'h43);
    idle(45);
    // R6 frozen
    wr(3, 'h40);
    idle(25);
    // R8 forced
    wr(3, 'h45);
    idle(8);
    wr(3, 'h44);
    idle(8);
    // R9 pwm
    wr(2, 5);
    wr(3, 'h46);
    idle(30);
    wr(3, 'h47);
    idle(30);
    // R4 prescaler shadow
    wr(0, 2);
    idle(70);
    wr(0, 0);
    idle(40);
    // R5 compare preload
    wr(3, 'h4E);
    idle(3);
    wr(2, 2);
    idle(30);
    wr(3, 'h46);
    wr(2, 8);
    idle(15);
    // R10 / R11
    wr(3, 'h56);
    idle(15);
    wr(3, 'h06);
    idle(15);
    // R12 external clear
    wr(3, 'hC5);
    idle(2);
    @(negedge clk); ext_clr = 1'b1;
    @(negedge clk); ext_clr = 1'b0;
    idle(25);
    // R3 clear requests hammered across wraps
    wr(1, 3);
    for (int i = 0; i < 20; i++) wr(4, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      ext_clr = ($urandom_range(0, 7) == 0);
      case (sel)
        0: wr(0, $urandom_range(0, 3));
        1: wr(1, $urandom_range(2, 12));
        2: wr(2, $urandom_range(0, 13));
        3: wr(3, $urandom_range(0, 255));
        4: wr(4, $urandom_range(0, 1));
        default: idle($urandom_range(1, 6));
      endcase
    end
    ext_clr = 1'b0;
    idle(5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule